// File: doc/BRIEF.md
# Vector Memory Address Generator

This block sequences the element addresses of one vector memory operation. A start command supplies a base address, a signed stride, an active length, an element size and an access mode. From these the block produces a stream of element addresses that the memory side can stall. It handles three kinds of access. Contiguous access steps by the element size. Strided access steps by a signed scalar amount. Indexed access adds each entry of an incoming offset stream to the base, and this one path serves both gathers and scatters.

Each offered address comes with the number of the memory bank it falls in. A conflict flag is raised when that bank was already used within the last few cycles. The load/store pipeline can use the flag to predict bank stalls or to account for them. Once started, the block sustains one address per clock while the downstream side accepts. It keeps its position through stalls. It pulses a completion strobe after the last element.

Top module: `vec_addr_gen`

## Requirements
- R1: With `modeI` = 0 (contiguous; code 3 behaves the same), element i has address `baseI + i * 2^sizeI`, so `sizeI` codes 0,1,2,3 select 1, 2, 4 and 8-byte elements.
- R2: With `modeI` = 1 (strided), the first address is `baseI`, and every later address is the previous one plus the signed `strideI`, wrapping modulo 2^AW.
- R3: With `modeI` = 2 (indexed), each address is `baseI` plus the current `idxI`. An offset is taken only when `idxValidI` and `idxReadyO` are both high. `idxReadyO` is high only while an indexed operation is running and `addrReadyI` is high.
- R4: An operation transfers exactly `vlenI` addresses, counted as cycles with both `addrValidO` and `addrReadyI` high.
- R5: A start with `vlenI` = 0 raises `doneO` in the next cycle and never raises `addrValidO`.
- R6: While `addrValidO` is high and `addrReadyI` is low in a contiguous or strided operation, the next cycle offers the same address again.
- R7: In contiguous or strided mode with `addrReadyI` held high, addresses come out on consecutive cycles, and `doneO` is seen `vlenI + 1` cycles after the start edge.
- R8: `doneO` is a pulse in the cycle after the last transfer. `busyO` is low from that cycle on.
- R9: `bankO` equals address bits `[OFFB + log2(BANKS) - 1 : OFFB]` of `addrO`.
- R10: `conflictO` is high exactly when `addrValidO` is high and `bankO` matches the bank of an address transferred in one of the previous `BUSY` cycles.
- R11: `startI` is ignored while `busyO` is high. The running stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start command, taken when idle |
| modeI | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 as 0 |
| sizeI | input | 2 | Element size as log2 of bytes |
| baseI | input | AW | Base byte address |
| strideI | input | AW | Signed byte stride for strided mode |
| vlenI | input | LW | Active element count |
| idxValidI | input | 1 | Offset stream valid |
| idxI | input | AW | Byte offset for indexed mode |
| idxReadyO | output | 1 | Offset consumed this cycle when valid |
| addrValidO | output | 1 | Address valid |
| addrReadyI | input | 1 | Downstream accepts the address |
| addrO | output | AW | Element byte address |
| bankO | output | log2(BANKS) | Bank number of `addrO` |
| conflictO | output | 1 | Bank recently used |
| busyO | output | 1 | Operation in progress |
| doneO | output | 1 | One-cycle completion strobe |

## Verification
A wrong running address or a stale stride shows up on the very next accepted element as a mismatched address and bank, so the scoreboard catches it within one transfer. A corrupted remaining count moves `doneO` away from the cycle after the last transfer. It also leaves expected addresses unconsumed, or produces unexpected ones, and this is visible at completion. A bad bank history shows up as a wrong `conflictO` in the first cycle that offers an address. The model compares the flag on every such cycle.

// File: rtl/vagen_pkg.sv
package vagen_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } accMode_e;

  // strobes from the sequencer to the address datapath
  typedef struct packed {
    logic load;     // start accepted this cycle
    logic step;     // advance the running address
    logic fire;     // address handed over this cycle
    logic offer;    // address valid this cycle
    logic indexed;  // running operation is indexed
  } ctlStrobe_t;

endpackage

// File: rtl/vagen_ctrl.sv
module vagen_ctrl
  import vagen_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startI,
  input  logic [1:0]    modeI,
  input  logic [LW-1:0] vlenI,
  input  logic          idxValidI,
  input  logic          addrReadyI,
  output ctlStrobe_t    ctlO,
  output logic          addrValidO,
  output logic          idxReadyO,
  output logic          busyO,
  output logic          doneO
);

  logic          busyQ;
  logic          idxModeQ;
  logic          doneQ;
  logic [LW-1:0] remQ;
  logic          accept;
  logic          offer;
  logic          fire;

  assign accept = startI & ~busyQ;
  assign offer  = busyQ & (~idxModeQ | idxValidI);
  assign fire   = offer & addrReadyI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      idxModeQ <= 1'b0;
      doneQ    <= 1'b0;
      remQ     <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        idxModeQ <= (accMode_e'(modeI) == MODE_INDEX);
        remQ     <= vlenI;
        busyQ    <= (vlenI != '0);
        doneQ    <= (vlenI == '0);
      end else if (fire) begin
        remQ <= remQ - LW'(1);
        if (remQ == LW'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctlO.load    = accept;
    ctlO.step    = fire & ~idxModeQ;
    ctlO.fire    = fire;
    ctlO.offer   = offer;
    ctlO.indexed = idxModeQ;
  end

  assign addrValidO = offer;
  assign idxReadyO  = busyQ & idxModeQ & addrReadyI;
  assign busyO      = busyQ;
  assign doneO      = doneQ;

endmodule

// File: rtl/vagen_dpath.sv
module vagen_dpath
  import vagen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BANKS = 8,
  parameter int OFFB  = 3,
  parameter int BUSY  = 4,
  localparam int BANKB = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctlI,
  input  logic [1:0]       modeI,
  input  logic [1:0]       sizeI,
  input  logic [AW-1:0]    baseI,
  input  logic [AW-1:0]    strideI,
  input  logic [AW-1:0]    idxI,
  output logic [AW-1:0]    addrO,
  output logic [BANKB-1:0] bankO,
  output logic             conflictO
);

  logic [AW-1:0]    baseQ;
  logic [AW-1:0]    curQ;
  logic [AW-1:0]    strideQ;
  logic             histV [BUSY];
  logic [BANKB-1:0] histB [BUSY];
  logic [BUSY-1:0]  hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      curQ    <= '0;
      strideQ <= '0;
    end else if (ctlI.load) begin
      baseQ <= baseI;
      curQ  <= baseI;
      if (accMode_e'(modeI) == MODE_STRIDE) strideQ <= strideI;
      else strideQ <= {{(AW-1){1'b0}}, 1'b1} << sizeI;
    end else if (ctlI.step) begin
      curQ <= curQ + strideQ;
    end
  end

  assign addrO = ctlI.indexed ? (baseQ + idxI) : curQ;
  assign bankO = addrO[OFFB +: BANKB];

  // banks of transfers in the last BUSY cycles, newest first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < BUSY; k++) begin
        histV[k] <= 1'b0;
        histB[k] <= '0;
      end
    end else begin
      histV[0] <= ctlI.fire;
      histB[0] <= bankO;
      for (int k = 1; k < BUSY; k++) begin
        histV[k] <= histV[k-1];
        histB[k] <= histB[k-1];
      end
    end
  end

  for (genvar g = 0; g < BUSY; g++) begin : gHit
    assign hit[g] = histV[g] && (histB[g] == bankO);
  end

  assign conflictO = ctlI.offer & (|hit);

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vagen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int BANKS = 8,
  parameter int OFFB  = 3,
  parameter int BUSY  = 4,
  localparam int BANKB = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [1:0]       modeI,
  input  logic [1:0]       sizeI,
  input  logic [AW-1:0]    baseI,
  input  logic [AW-1:0]    strideI,
  input  logic [LW-1:0]    vlenI,
  input  logic             idxValidI,
  input  logic [AW-1:0]    idxI,
  output logic             idxReadyO,
  output logic             addrValidO,
  input  logic             addrReadyI,
  output logic [AW-1:0]    addrO,
  output logic [BANKB-1:0] bankO,
  output logic             conflictO,
  output logic             busyO,
  output logic             doneO
);

  ctlStrobe_t ctl;
  logic       isIndexed;

  vagen_ctrl #(.LW(LW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .modeI      (modeI),
    .vlenI      (vlenI),
    .idxValidI  (idxValidI),
    .addrReadyI (addrReadyI),
    .ctlO       (ctl),
    .addrValidO (addrValidO),
    .idxReadyO  (idxReadyO),
    .busyO      (busyO),
    .doneO      (doneO)
  );

  vagen_dpath #(.AW(AW), .BANKS(BANKS), .OFFB(OFFB), .BUSY(BUSY)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctlI      (ctl),
    .modeI     (modeI),
    .sizeI     (sizeI),
    .baseI     (baseI),
    .strideI   (strideI),
    .idxI      (idxI),
    .addrO     (addrO),
    .bankO     (bankO),
    .conflictO (conflictO)
  );

  assign isIndexed = ctl.indexed;

endmodule

// File: rtl/vagen_chk.sv
module vagen_chk #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          startI,
  input logic [LW-1:0] vlenI,
  input logic          addrValidO,
  input logic          addrReadyI,
  input logic [AW-1:0] addrO,
  input logic          idxReadyO,
  input logic          busyO,
  input logic          doneO,
  input logic          isIndexed
);

  logic [LW-1:0] lenQ;
  logic [LW-1:0] seenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ  <= '0;
      seenQ <= '0;
    end else if (startI && !busyO) begin
      lenQ  <= vlenI;
      seenQ <= '0;
    end else if (addrValidO && addrReadyI) begin
      seenQ <= seenQ + LW'(1);
    end
  end

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    addrValidO && !addrReadyI && !isIndexed |=> addrValidO && $stable(addrO)); // R6

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    busyO && !isIndexed |-> addrValidO); // R7

  AST_IDX_READY: assert property (@(posedge clk) disable iff (!rstN)
    idxReadyO |-> addrReadyI && busyO && isIndexed); // R3

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    startI && !busyO && vlenI == '0 |=> doneO && !busyO && !addrValidO); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !busyO && !addrValidO); // R8

  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> seenQ == lenQ); // R4

endmodule

bind vec_addr_gen vagen_chk #(.AW(AW), .LW(LW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startI     (startI),
  .vlenI      (vlenI),
  .addrValidO (addrValidO),
  .addrReadyI (addrReadyI),
  .addrO      (addrO),
  .idxReadyO  (idxReadyO),
  .busyO      (busyO),
  .doneO      (doneO),
  .isIndexed  (isIndexed)
);

// File: tb/sim_vec_addr_gen.sv
`timescale 1ns/1ps
module sim_vec_addr_gen;

  localparam int AW = 32;
  localparam int LW = 8;
  localparam int BANKS = 8;
  localparam int OFFB = 3;
  localparam int BUSY = 4;
  localparam int BANKB = $clog2(BANKS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [1:0] modeI = '0;
  logic [1:0] sizeI = '0;
  logic [AW-1:0] baseI = '0;
  logic [AW-1:0] strideI = '0;
  logic [LW-1:0] vlenI = '0;
  logic idxValidI = 1'b0;
  logic [AW-1:0] idxI = '0;
  logic idxReadyO;
  logic addrValidO;
  logic addrReadyI = 1'b0;
  logic [AW-1:0] addrO;
  logic [BANKB-1:0] bankO;
  logic conflictO;
  logic busyO;
  logic doneO;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] expQ[$];
  logic [AW-1:0] idxFeedQ[$];
  bit readyAll = 1'b1;
  bit curIdx = 1'b0;
  bit chkRate = 1'b0;
  bit idxTaken = 1'b0;
  bit holdPend = 1'b0;
  logic [AW-1:0] holdAddr = '0;
  bit monOn = 1'b0;
  int confCnt = 0;
  string curReq = "R1";
  logic [15:0] lfsr = 16'hACE1;
  bit hv[BUSY];
  logic [BANKB-1:0] hb[BUSY];

  always #2.5 clk = ~clk;

  vec_addr_gen #(.AW(AW), .LW(LW), .BANKS(BANKS), .OFFB(OFFB), .BUSY(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .modeI(modeI), .sizeI(sizeI),
    .baseI(baseI), .strideI(strideI), .vlenI(vlenI), .idxValidI(idxValidI),
    .idxI(idxI), .idxReadyO(idxReadyO), .addrValidO(addrValidO),
    .addrReadyI(addrReadyI), .addrO(addrO), .bankO(bankO),
    .conflictO(conflictO), .busyO(busyO), .doneO(doneO)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // input drivers for ready and the offset stream
  always @(posedge clk) begin
    #1;
    if (idxTaken && idxFeedQ.size() > 0) void'(idxFeedQ.pop_front());
    idxValidI = (idxFeedQ.size() > 0) && lfsr[1];
    idxI = (idxFeedQ.size() > 0) ? idxFeedQ[0] : '0;
    addrReadyI = readyAll | lfsr[0] | lfsr[4];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // monitor: scoreboard pop and bank model
  always @(negedge clk) begin
    bit fire;
    bit expConf;
    logic [AW-1:0] e;
    logic [BANKB-1:0] expBank;
    fire = addrValidO && addrReadyI;
    idxTaken = idxValidI && idxReadyO;
    if (monOn) begin
      expConf = 1'b0;
      for (int j = 0; j < BUSY; j++) if (hv[j] && hb[j] == bankO) expConf = 1'b1;
      expConf = expConf && addrValidO;
      if (addrValidO || conflictO)
        check(conflictO == expConf, "R10", "conflict flag", 64'(conflictO), 64'(expConf));
      if (addrValidO && conflictO) confCnt++;
      if (idxReadyO && !curIdx)
        check(1'b0, "R3", "offset ready outside indexed op", 1, 0);
      if (holdPend && !curIdx)
        check(addrValidO && addrO == holdAddr, "R6", "held address", 64'(addrO), 64'(holdAddr));
      if (chkRate && busyO)
        check(addrValidO, "R7", "gap in full-rate stream", 64'(addrValidO), 1);
      if (fire) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "address beyond active length", 64'(addrO), 0);
        end else begin
          e = expQ.pop_front();
          check(addrO == e, curReq, "element address", 64'(addrO), 64'(e));
          expBank = BANKB'(e >> OFFB);
          check(bankO == expBank, "R9", "bank number", 64'(bankO), 64'(expBank));
        end
      end
      holdPend = addrValidO && !addrReadyI && !curIdx;
      holdAddr = addrO;
      for (int j = BUSY - 1; j > 0; j--) begin
        hv[j] = hv[j-1];
        hb[j] = hb[j-1];
      end
      hv[0] = fire;
      hb[0] = bankO;
    end
  end

  task automatic runOp(input logic [1:0] mode, input logic [AW-1:0] base,
                       input logic [AW-1:0] stride, input logic [1:0] size,
                       input int len, input bit allReady, input bit glitch,
                       input string req);
    logic [AW-1:0] step;
    int waited;
    step = (mode == 2'd1) ? stride : (AW'(1) << size);
    for (int i = 0; i < len; i++) begin
      if (mode == 2'd2) begin
        logic [AW-1:0] off;
        off = AW'(i * 40 + (i % 3) * 1024);
        idxFeedQ.push_back(off);
        expQ.push_back(base + off);
      end else begin
        expQ.push_back(base + AW'(i) * step);
      end
    end
    curReq = req;
    curIdx = (mode == 2'd2);
    readyAll = allReady;
    chkRate = allReady && (mode != 2'd2);
    confCnt = 0;
    @(posedge clk); #1;
    startI = 1'b1; modeI = mode; baseI = base; strideI = stride;
    sizeI = size; vlenI = LW'(len);
    @(posedge clk); #1;
    startI = 1'b0;
    if (glitch) begin
      fork
        begin
          repeat (2) @(posedge clk);
          #1;
          startI = 1'b1; baseI = 32'h0BAD_0000; vlenI = 8'd3; modeI = 2'd0;
          @(posedge clk); #1;
          startI = 1'b0;
        end
      join_none
    end
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!doneO && waited < 2000);
    check(doneO, "R8", "done seen", 64'(doneO), 1);
    check(expQ.size() == 0, "R4", "addresses left unissued", 64'(expQ.size()), 0);
    check(!busyO, "R8", "busy low with done", 64'(busyO), 0);
    if (chkRate)
      check(waited == len + 1, "R7", "cycles from start to done", 64'(waited), 64'(len + 1));
    @(negedge clk);
    check(!doneO, "R8", "done is a single pulse", 64'(doneO), 0);
    chkRate = 1'b0;
    readyAll = 1'b1;
    repeat (BUSY + 2) @(negedge clk);
    expQ.delete();
    idxFeedQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < BUSY; j++) begin hv[j] = 1'b0; hb[j] = '0; end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!addrValidO && !busyO && !doneO && !idxReadyO && !conflictO, "R8",
          "reset state", {59'd0, addrValidO, busyO, doneO, idxReadyO, conflictO}, 0);
    monOn = 1'b1;

    // R1: contiguous 8-byte elements rotate through banks, no conflicts
    runOp(2'd0, 32'h0000_1000, '0, 2'd3, 12, 1'b1, 1'b0, "R1");
    check(confCnt == 0, "R10", "no conflicts on rotating banks", 64'(confCnt), 0);
    // R1: other element sizes, with stalls (R6)
    runOp(2'd0, 32'h0000_2003, '0, 2'd0, 9, 1'b0, 1'b0, "R1");
    runOp(2'd0, 32'h0000_3000, '0, 2'd1, 11, 1'b0, 1'b0, "R1");
    runOp(2'd3, 32'h0000_4000, '0, 2'd2, 7, 1'b1, 1'b0, "R1");
    // R2: stride hitting one bank each time, R10 conflicts expected
    runOp(2'd1, 32'h0001_0000, 32'd64, 2'd3, 10, 1'b1, 1'b0, "R2");
    check(confCnt > 0, "R10", "same-bank stride flags conflicts", 64'(confCnt), 1);
    // R2 with negative stride, stalls, and R11 start while busy
    runOp(2'd1, 32'h0002_0000, -32'sd24, 2'd2, 20, 1'b0, 1'b1, "R11");
    // R3: indexed with gaps on both streams
    runOp(2'd2, 32'h0003_0000, '0, 2'd0, 16, 1'b0, 1'b0, "R3");
    runOp(2'd2, 32'h0004_0000, '0, 2'd0, 6, 1'b1, 1'b0, "R3");
    // R5: zero length
    runOp(2'd0, 32'h0005_0000, '0, 2'd3, 0, 1'b1, 1'b0, "R5");
    check(expQ.size() == 0, "R5", "no addresses for zero length", 64'(expQ.size()), 0);
    // R4: longest active length
    runOp(2'd0, 32'hFFFF_FF00, '0, 2'd2, 255, 1'b1, 1'b0, "R4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule